// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block is a four-stage ring counter that passes a single 1 around its stages. It is a left-shifting register. On every enabled clock edge each stage takes the value of the stage to its right. The rightmost stage takes a fill bit, which is computed from the register's own contents. The fill bit is 1 only when every stage except the leftmost holds 0. This one rule starts the ring from the all-zero state. It also drains any other pattern into the one-hot loop within a bounded number of edges, with no separate illegal-state decoder.

A synchronous active-low initialize input clears the register to all zeros. The next enabled edge then enters the first one-hot state. A count enable pauses the ring when low. A flag output marks whether the present state is a legal one-hot pattern. The register's value before the first clock edge is a parameter. This lets an integration or test bench place the ring in any pattern and watch it recover.

Top module: `ring_counter_sc`

## Requirements
- R1: On an edge with initialize inactive and enable high, the state shifts left. Bit 3 (A, most significant) takes bit 2, bit 2 takes bit 1, bit 1 takes bit 0, and bit 0 (D) takes the fill bit.
- R2: The fill bit is 1 exactly when bits 2, 1 and 0 are all 0, that is, from states 0000 and 1000. From the other 14 states it is 0.
- R3: With `initN` low at an edge, the state becomes 0000 after that edge, whatever `countEn` is.
- R4: With `initN` high and `countEn` low at an edge, the state does not change.
- R5: From 0000 one enabled edge gives 0001. After that the state runs 0001, 0010, 0100, 1000, 0001, repeating every four enabled edges.
- R6: `legal` is high exactly when one and only one of the four state bits is 1.
- R7: From any of the 16 states, the ring is one-hot after at most 3 enabled edges and stays in the R5 loop from then on.
- R8: 1001 reaches 0010 in one edge. 1101 passes 1010 and reaches 0100 in two edges. 0111 passes 1110 and 1100 and reaches 1000 in three edges.
- R9: Before the first clock edge the state equals the `POWER_UP_STATE` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| initN | input | 1 | Synchronous initialize to 0000, active low, has priority |
| countEn | input | 1 | Shift enable; state holds when low |
| stateQ | output | 4 | Ring state; bit 3 is A, bit 0 is D |
| legal | output | 1 | High when the state is one-hot |

## Verification
The whole state appears on `stateQ`, so a wrong fill term or a wrong shift direction shows at the ports on the first enabled edge after the state it affects. A fill bit forced to 1 breaks the loop within four edges of a legal state. A fill bit stuck at 0 leaves the ring empty right after initialize. Fault-free recovery paths take up to three edges. For that reason every one of the 16 power-up patterns is traced edge by edge against an independent shift model, rather than checked only at the end.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clear;  // load all zeros
    logic shift;  // shift left with computed fill
  } ringStrobes_t;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
(
  input  logic         initN,
  input  logic         countEn,
  output ringStrobes_t strobes
);
  // Initialize wins over enable (R3)
  always_comb begin
    strobes.clear = ~initN;
    strobes.shift = initN & countEn;
  end
endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import ring_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] POWER_UP_STATE = '0
) (
  input  logic             clk,
  input  ringStrobes_t     strobes,
  output logic [WIDTH-1:0] state,
  output logic             legal
);
  localparam int unsigned LOW_BITS = WIDTH - 1;

  logic [WIDTH-1:0] stateReg = POWER_UP_STATE;
  logic [WIDTH-1:0] stateNext;
  logic             fillBit;
  logic             pastValid = 1'b0;

  // Fill is 1 only when every bit below the MSB is clear (R2)
  assign fillBit = ~|stateReg[LOW_BITS-1:0];

  always_comb begin
    stateNext = stateReg;
    if (strobes.clear)      stateNext = '0;
    else if (strobes.shift) stateNext = {stateReg[LOW_BITS-1:0], fillBit};
  end

  always_ff @(posedge clk) begin
    stateReg  <= stateNext;
    pastValid <= 1'b1;
  end

  assign state = stateReg;
  assign legal = $onehot(stateReg);

  // R3: clear strobe empties the ring
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!pastValid)
    strobes.clear |=> (state == '0));

  // R4: no strobe, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!pastValid)
    (!strobes.clear && !strobes.shift) |=> $stable(state));

  // R1: upper bits take the lower bits
  p_shift_left_r1: assert property (@(posedge clk) disable iff (!pastValid)
    (strobes.shift && !strobes.clear) |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])));

  // R5: empty ring restarts with a single one at bit 0
  p_restart_r5: assert property (@(posedge clk) disable iff (!pastValid)
    (strobes.shift && !strobes.clear && state == '0) |=> (state == WIDTH'(1)));

  // R7: a legal state stays legal while shifting
  p_stay_legal_r7: assert property (@(posedge clk) disable iff (!pastValid)
    (strobes.shift && !strobes.clear && legal) |=> legal);
endmodule

// File: rtl/ring_counter_sc.sv
module ring_counter_sc
  import ring_pkg::*;
#(
  parameter logic [3:0] POWER_UP_STATE = 4'b0000
) (
  input  logic       clk,
  input  logic       initN,
  input  logic       countEn,
  output logic [3:0] stateQ,
  output logic       legal
);
  localparam int unsigned WIDTH = 4;

  ringStrobes_t strobes;
  logic         seenEdge = 1'b0;

  ring_ctrl u_ctrl (
    .initN   (initN),
    .countEn (countEn),
    .strobes (strobes)
  );

  ring_datapath #(
    .WIDTH          (WIDTH),
    .POWER_UP_STATE (POWER_UP_STATE)
  ) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .state   (stateQ),
    .legal   (legal)
  );

  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R3: port-level initialize priority
  p_init_priority_r3: assert property (@(posedge clk) disable iff (!seenEdge)
    (!initN && countEn) |=> (stateQ == 4'b0000));
endmodule

// File: tb/ring_counter_sc_test.sv
module ring_counter_sc_test;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       initN = 1'b1;
  logic       countEn = 1'b0;
  logic       probeEn = 1'b0;
  logic [3:0] stateQ;
  logic       legal;
  logic [3:0] probeQ [16];
  logic       probeLegal [16];
  int         nChecks = 0;
  int         nFails = 0;

  always #2 clk = ~clk;  // 250 MHz

  ring_counter_sc uut (
    .clk(clk), .initN(initN), .countEn(countEn), .stateQ(stateQ), .legal(legal)
  );

  for (genvar g = 0; g < 16; g++) begin : g_probe
    ring_counter_sc #(.POWER_UP_STATE(4'(g))) probe (
      .clk(clk), .initN(1'b1), .countEn(probeEn),
      .stateQ(probeQ[g]), .legal(probeLegal[g])
    );
  end

  // Reference model built from R1 and R2
  function automatic logic [3:0] refNext(input logic [3:0] s);
    return {s[2:0], (s[2:0] == 3'b000)};
  endfunction

  function automatic logic refLegal(input logic [3:0] s);
    return (s == 4'b0001) || (s == 4'b0010) || (s == 4'b0100) || (s == 4'b1000);
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, sample 1 ns after the posedge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic i, input logic e);
    @(negedge clk);
    initN = i; countEn = e;
  endtask

  task automatic test_powerup();
    check("R9 uut power-up", stateQ, 4'b0000);
    check("R6 legal at 0000", {3'b0, legal}, 4'd0);
    for (int i = 0; i < 16; i++) begin
      check("R9 probe power-up", probeQ[i], 4'(i));
      check("R6 legal flag", {3'b0, probeLegal[i]}, {3'b0, refLegal(4'(i))});
    end
  endtask

  task automatic test_init_and_cycle();
    drive(1'b0, 1'b1); step();
    check("R3 init with enable high", stateQ, 4'b0000);
    drive(1'b1, 1'b1); step();
    check("R5 0000 to 0001", stateQ, 4'b0001);
    check("R6 legal after restart", {3'b0, legal}, 4'd1);
    step(); check("R5 to 0010", stateQ, 4'b0010);
    step(); check("R5 to 0100", stateQ, 4'b0100);
    step(); check("R5 to 1000", stateQ, 4'b1000);
    step(); check("R5 wrap to 0001", stateQ, 4'b0001);
  endtask

  task automatic test_hold();
    drive(1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(); check("R4 hold with enable low", stateQ, 4'b0001);
    end
    drive(1'b1, 1'b1); step();
    check("R4 resume after hold", stateQ, 4'b0010);
    drive(1'b0, 1'b0); step();
    check("R3 init with enable low", stateQ, 4'b0000);
    drive(1'b1, 1'b0); step();
    check("R4 zero holds without enable", stateQ, 4'b0000);
  endtask

  task automatic test_recovery();
    logic [3:0] model [16];
    for (int i = 0; i < 16; i++) model[i] = 4'(i);
    @(negedge clk); probeEn = 1'b1;
    for (int t = 1; t <= 7; t++) begin
      step();
      for (int i = 0; i < 16; i++) begin
        model[i] = refNext(model[i]);
        check("R1 R2 probe vs shift model", probeQ[i], model[i]);
        if (t >= 3) check("R7 one-hot within 3 edges", {3'b0, probeLegal[i]}, 4'd1);
      end
      if (t == 1) check("R8 1001 to 0010", probeQ[9], 4'b0010);
      if (t == 1) check("R8 1101 to 1010", probeQ[13], 4'b1010);
      if (t == 2) check("R8 1101 to 0100", probeQ[13], 4'b0100);
      if (t == 2) check("R8 0111 to 1100", probeQ[7], 4'b1100);
      if (t == 3) check("R8 0111 to 1000", probeQ[7], 4'b1000);
    end
    @(negedge clk); probeEn = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    #1;
    test_powerup();
    test_init_and_cycle();
    test_hold();
    test_recovery();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule